// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller (Processor Side)

This block sits on the processor module and arbitrates three prioritised interrupt request lines, level 3 being the most urgent. While the processor keeps its interrupt enable raised and nothing is latched, the block pulses a sync strobe toward the devices. On each falling edge of that strobe it samples the requests through a 2-bit level mask and latches the most urgent request that the mask allows. It then raises the processor interrupt, drives the one acknowledge line for that level, and answers the processor's interrupt-acknowledge cycle with a one-byte restart opcode that selects a per-level service entry.

The service routine then reads the controller's I/O port to find which device interrupted. That read raises the daisy-chained grant. The first requesting device on the chain answers with its vector and a vector-valid flag. The read completes with that vector, or with 0xFF when no device answers within a bounded wait, and the latched level is released. The same port, when written, loads the mask. A mask code disables levels cumulatively from the lowest upward.

Top module: `tri_level_irq_ctrl`

## Requirements
- R1: A write with `io_addr_i` equal to the port address (default 0xFF) loads `io_wdata_i[1:0]` into the mask on the next edge; the upper data bits are dropped and writes to any other address leave the mask unchanged.
- R2: Mask code m enables exactly the levels k (1..3) with k > m: code 0 enables all, 1 enables levels 2 and 3, 2 enables level 3 only, 3 enables none. A masked request is never latched.
- R3: `sync_o` goes high on the edge after one where `cpu_ie_i` is high, nothing is latched and `sync_o` is low; it is low in every other cycle, so it toggles every cycle while enabled and idle.
- R4: On the edge where `sync_o` is high, the most urgent enabled request (level 3 over 2 over 1) is latched and `cpu_int_o` rises; if no enabled request is present nothing is latched.
- R5: `ack_o` has exactly one bit set while a level is latched, bit k-1 for level k, and is all zero otherwise.
- R6: While `cpu_inta_i` is high and a level L is latched, `inta_data_o` carries 11AAA111 with AAA = L (0xCF, 0xD7, 0xDF for levels 1, 2, 3); otherwise it is 0x00.
- R7: A read pulse on `io_rd_i` at the port address raises `grant_o` on the next edge; on the edge that sees `vec_valid_i` while granted, `io_rdata_o` takes `dev_data_i`, `io_ready_o` pulses for one cycle, `grant_o` drops and the latched level is released.
- R8: If `vec_valid_i` never arrives, `grant_o` stays high for exactly TIMEOUT cycles, then `io_rdata_o` becomes 0xFF, `io_ready_o` pulses and the latched level is released.
- R9: After reset the mask is 3, nothing is latched, and `sync_o`, `ack_o`, `cpu_int_o`, `grant_o`, `io_ready_o` and `io_rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ie_i | input | 1 | Processor interrupt enable flag |
| cpu_inta_i | input | 1 | Processor is in its interrupt-acknowledge cycle |
| cpu_int_o | output | 1 | Interrupt request to the processor |
| inta_data_o | output | 8 | Restart opcode for the acknowledge cycle |
| io_wr_i | input | 1 | I/O write pulse |
| io_rd_i | input | 1 | I/O read request pulse |
| io_addr_i | input | 8 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Read data from the last completed port read |
| io_ready_o | output | 1 | One-cycle completion pulse for a port read |
| req_i | input | 3 | Request lines, bit k-1 for level k |
| ack_o | output | 3 | Acknowledge lines, bit k-1 for level k |
| sync_o | output | 1 | Sync strobe to the devices |
| grant_o | output | 1 | Daisy-chain grant out |
| vec_valid_i | input | 1 | Device vector is valid |
| dev_data_i | input | 8 | Low data byte carrying the device vector |

## Verification
The bench walks every mask code against request patterns that sit just below and just above the enabled boundary; a design with an off-by-one mask decode would latch a level it should block, or block level 3 under code 2. Simultaneous requests on several levels check the priority order, where a reversed encoder would return the level-1 opcode 0xCF instead of 0xDF. A read with no answering device checks that the grant lasts exactly the timeout and yields 0xFF; a design that forgot to release the level on timeout would keep its acknowledge line high forever. Writes to a foreign port address and writes with upper data bits set confirm the mask ignores them.

// File: rtl/irq3_pkg.sv
package irq3_pkg;

  typedef enum logic {PORT_IDLE, PORT_WAIT} port_state_t;

  // Level k (1..3) is enabled when k exceeds the mask code.
  function automatic logic level_enabled(input logic [1:0] code, input int k);
    level_enabled = (k > int'(code));
  endfunction

  // Most urgent enabled request; 0 means none.
  function automatic logic [1:0] pick_level(input logic [2:0] req, input logic [1:0] code);
    pick_level = 2'd0;
    for (int k = 1; k <= 3; k++)
      if (req[k-1] && level_enabled(code, k)) pick_level = 2'(k);
  endfunction

  // Restart opcode 11AAA111 with AAA taken from the level.
  function automatic logic [7:0] restart_opcode(input logic [1:0] lvl);
    restart_opcode = {2'b11, 1'b0, lvl, 3'b111};
  endfunction

endpackage

// File: rtl/irq3_mask_reg.sv
module irq3_mask_reg #(
  parameter logic [7:0] PORT_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [1:0] mask_o
);
  logic hit;
  assign hit = wr_i && (addr_i == PORT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_o <= 2'd3;
    else if (hit) mask_o <= wdata_i[1:0];
  end
endmodule

// File: rtl/irq3_level_latch.sv
module irq3_level_latch
  import irq3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ie_i,
  input  logic [2:0] req_i,
  input  logic [1:0] mask_i,
  input  logic       release_i,
  output logic       sync_o,
  output logic       latch_ev_o,
  output logic [1:0] lvl_o
);
  logic [1:0] chosen;
  logic       sync_q;

  assign chosen     = pick_level(req_i, mask_i);
  assign latch_ev_o = sync_q && (chosen != 2'd0);
  assign sync_o     = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      lvl_o  <= 2'd0;
    end else begin
      sync_q <= cpu_ie_i && (lvl_o == 2'd0) && !sync_q;
      if (latch_ev_o)     lvl_o <= chosen;
      else if (release_i) lvl_o <= 2'd0;
    end
  end
endmodule

// File: rtl/irq3_vector_port.sv
module irq3_vector_port
  import irq3_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR = 8'hFF,
  parameter int         TIMEOUT   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic       vec_valid_i,
  input  logic [7:0] dev_data_i,
  output logic       grant_o,
  output logic       ready_o,
  output logic [7:0] rdata_o,
  output logic       done_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  port_state_t     st;
  logic [TW-1:0]   tmr;
  logic            expired;

  assign grant_o = (st == PORT_WAIT);
  assign expired = grant_o && !vec_valid_i && (tmr == TW'(TIMEOUT - 1));
  assign done_o  = grant_o && (vec_valid_i || expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PORT_IDLE;
      tmr     <= '0;
      ready_o <= 1'b0;
      rdata_o <= 8'h00;
    end else begin
      ready_o <= done_o;
      case (st)
        PORT_IDLE: if (rd_i && addr_i == PORT_ADDR) begin
          st  <= PORT_WAIT;
          tmr <= '0;
        end
        PORT_WAIT: begin
          if (vec_valid_i) begin
            rdata_o <= dev_data_i;
            st      <= PORT_IDLE;
          end else if (expired) begin
            rdata_o <= 8'hFF;
            st      <= PORT_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= PORT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tri_level_irq_ctrl.sv
module tri_level_irq_ctrl
  import irq3_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR = 8'hFF,
  parameter int         TIMEOUT   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ie_i,
  input  logic       cpu_inta_i,
  output logic       cpu_int_o,
  output logic [7:0] inta_data_o,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic [7:0] io_addr_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  output logic       io_ready_o,
  input  logic [2:0] req_i,
  output logic [2:0] ack_o,
  output logic       sync_o,
  output logic       grant_o,
  input  logic       vec_valid_i,
  input  logic [7:0] dev_data_i
);
  localparam int NLEV = 3;

  logic [1:0] mask_q;
  logic [1:0] lvl_q;
  logic       latch_ev;
  logic       read_done;

  irq3_mask_reg #(.PORT_ADDR(PORT_ADDR)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(io_wr_i), .addr_i(io_addr_i),
    .wdata_i(io_wdata_i), .mask_o(mask_q)
  );

  irq3_level_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cpu_ie_i(cpu_ie_i), .req_i(req_i),
    .mask_i(mask_q), .release_i(read_done), .sync_o(sync_o),
    .latch_ev_o(latch_ev), .lvl_o(lvl_q)
  );

  irq3_vector_port #(.PORT_ADDR(PORT_ADDR), .TIMEOUT(TIMEOUT)) u_port (
    .clk(clk), .rst_n(rst_n), .rd_i(io_rd_i), .addr_i(io_addr_i),
    .vec_valid_i(vec_valid_i), .dev_data_i(dev_data_i), .grant_o(grant_o),
    .ready_o(io_ready_o), .rdata_o(io_rdata_o), .done_o(read_done)
  );

  for (genvar g = 0; g < NLEV; g++) begin : g_ack
    assign ack_o[g] = (lvl_q == 2'(g + 1));
  end

  assign cpu_int_o   = (lvl_q != 2'd0);
  assign inta_data_o = (cpu_inta_i && cpu_int_o) ? restart_opcode(lvl_q) : 8'h00;
endmodule

// File: rtl/irq3_checker.sv
module irq3_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ie_i,
  input logic       cpu_inta_i,
  input logic       cpu_int_o,
  input logic [7:0] inta_data_o,
  input logic [2:0] ack_o,
  input logic       sync_o,
  input logic       grant_o,
  input logic       vec_valid_i,
  input logic [7:0] dev_data_i,
  input logic       io_ready_o,
  input logic [7:0] io_rdata_o,
  input logic [1:0] mask_w,
  input logic       latch_ev_w
);
  p_one_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  p_sync_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> $past(cpu_ie_i));

  p_code3_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && mask_w == 2'd3) |-> !latch_ev_w);

  p_opcode_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_inta_i && cpu_int_o) |-> (inta_data_o[7:6] == 2'b11 && inta_data_o[2:0] == 3'b111));

  p_vector_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && vec_valid_i) |=> (io_ready_o && !grant_o && io_rdata_o == $past(dev_data_i)));

  p_latch_raises_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev_w |=> cpu_int_o);
endmodule

bind tri_level_irq_ctrl irq3_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ie_i(cpu_ie_i), .cpu_inta_i(cpu_inta_i),
  .cpu_int_o(cpu_int_o), .inta_data_o(inta_data_o), .ack_o(ack_o),
  .sync_o(sync_o), .grant_o(grant_o), .vec_valid_i(vec_valid_i),
  .dev_data_i(dev_data_i), .io_ready_o(io_ready_o), .io_rdata_o(io_rdata_o),
  .mask_w(mask_q), .latch_ev_w(latch_ev)
);

// File: tb/tri_level_irq_ctrl_test.sv
module tri_level_irq_ctrl_test;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_ie = 0, cpu_inta = 0, io_wr = 0, io_rd = 0, vv = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, dev = 0;
  logic [2:0] req = 0;
  logic cpu_int, io_ready, sync, grant;
  logic [7:0] inta_data, io_rdata;
  logic [2:0] ack;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tri_level_irq_ctrl #(.PORT_ADDR(8'hFF), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_ie_i(cpu_ie), .cpu_inta_i(cpu_inta),
    .cpu_int_o(cpu_int), .inta_data_o(inta_data), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .io_ready_o(io_ready), .req_i(req), .ack_o(ack), .sync_o(sync),
    .grant_o(grant), .vec_valid_i(vv), .dev_data_i(dev)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_mask = 3, m_lvl = 0, m_tmr = 0, m_rdata = 0;
  bit m_sync = 0, m_busy = 0, m_ready = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 3; m_lvl = 0; m_tmr = 0; m_rdata = 0;
      m_sync = 0; m_busy = 0; m_ready = 0;
    end else begin
      bit nsync;
      int best;
      nsync = cpu_ie && (m_lvl == 0) && !m_sync;
      best = 0;
      if (m_sync) begin
        if (req[0] && m_mask < 1) best = 1;
        if (req[1] && m_mask < 2) best = 2;
        if (req[2] && m_mask < 3) best = 3;
      end
      m_ready = 0;
      if (m_busy) begin
        if (vv) begin
          m_rdata = dev; m_ready = 1; m_busy = 0; m_lvl = 0;
        end else if (m_tmr == TO - 1) begin
          m_rdata = 8'hFF; m_ready = 1; m_busy = 0; m_lvl = 0;
        end else m_tmr++;
      end else if (io_rd && io_addr == 8'hFF) begin
        m_busy = 1; m_tmr = 0;
      end
      if (best != 0) m_lvl = best;
      if (io_wr && io_addr == 8'hFF) m_mask = io_wdata & 3;
      m_sync = nsync;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_op;
      exp_op = (cpu_inta && m_lvl != 0) ? (8'hC7 | (m_lvl << 3)) : 0;
      chk(sync == m_sync, "R3 sync", sync, m_sync);
      chk(cpu_int == (m_lvl != 0), "R4 int", cpu_int, m_lvl != 0);
      chk(ack == ((m_lvl == 0) ? 3'b000 : 3'(1 << (m_lvl - 1))), "R5 ack", ack,
          (m_lvl == 0) ? 0 : (1 << (m_lvl - 1)));
      chk(inta_data == 8'(exp_op), "R6 opcode", inta_data, exp_op);
      chk(grant == m_busy, "R7 grant", grant, m_busy);
      chk(io_ready == m_ready, "R7 ready", io_ready, m_ready);
      chk(io_rdata == 8'(m_rdata), "R7 rdata", io_rdata, m_rdata);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    io_wr = 1; io_addr = a; io_wdata = d;
    tick(1);
    io_wr = 0; io_addr = 0;
  endtask

  task automatic port_read(input bit respond, input logic [7:0] vec, output logic [7:0] got,
                           output int gcycles);
    io_rd = 1; io_addr = 8'hFF;
    tick(1);
    io_rd = 0; io_addr = 0;
    gcycles = 0;
    if (respond) begin
      tick(3);
      vv = 1; dev = vec;
    end
    for (int i = 0; i < 100 && !io_ready; i++) begin
      if (grant) gcycles++;
      tick(1);
    end
    got = io_rdata;
    vv = 0;
  endtask

  // Emulated processor: enable, wait for interrupt, run acknowledge cycle.
  task automatic take_irq(input int exp_lvl, input string tag);
    int waited;
    cpu_ie = 1;
    waited = 0;
    for (int i = 0; i < 20 && !cpu_int; i++) begin tick(1); waited++; end
    cpu_ie = 0;
    chk(cpu_int == 1, tag, cpu_int, 1);
    cpu_inta = 1;
    tick(1);
    chk(inta_data == 8'(8'hC7 | (exp_lvl << 3)), "R6 restart opcode", inta_data,
        8'hC7 | (exp_lvl << 3));
    chk(ack == 3'(1 << (exp_lvl - 1)), "R5 single ack", ack, 1 << (exp_lvl - 1));
    cpu_inta = 0;
  endtask

  task automatic expect_none(input string tag);
    cpu_ie = 1;
    tick(20);
    chk(cpu_int == 0 && ack == 0, tag, {cpu_int, ack}, 0);
    cpu_ie = 0;
    tick(2);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int gc;
    tick(3);
    rst_n = 1;
    tick(1);
    // R9 reset state
    chk(sync == 0 && ack == 0 && cpu_int == 0 && grant == 0 && io_ready == 0 && io_rdata == 0,
        "R9 reset outputs", {sync, ack, cpu_int, grant, io_ready, io_rdata}, 0);
    req = 3'b111;
    expect_none("R9 mask resets to 3");
    // R1 foreign address ignored
    io_write(8'h10, 8'h00);
    expect_none("R1 foreign port write ignored");
    // R1 upper bits dropped: 0x04 -> code 0
    io_write(8'hFF, 8'h04);
    take_irq(3, "R4 priority level 3");
    port_read(1, 8'h5A, got, gc);
    chk(got == 8'h5A, "R7 vector returned", got, 8'h5A);
    chk(ack == 0 && cpu_int == 0, "R7 level released", ack, 0);
    // R2 code 0, level 1 alone
    req = 3'b001;
    take_irq(1, "R2 code0 level1");
    port_read(1, 8'h11, got, gc);
    // R2 code 1
    io_write(8'hFF, 8'h01);
    expect_none("R2 code1 blocks level1");
    req = 3'b011;
    take_irq(2, "R4 code1 picks level2");
    port_read(1, 8'h22, got, gc);
    chk(got == 8'h22, "R7 vector level2", got, 8'h22);
    // R2 code 2
    io_write(8'hFF, 8'h02);
    req = 3'b011;
    expect_none("R2 code2 blocks level2");
    req = 3'b100;
    take_irq(3, "R2 code2 passes level3");
    // R8 timeout
    port_read(0, 8'h00, got, gc);
    chk(got == 8'hFF, "R8 timeout data", got, 8'hFF);
    chk(gc == TO, "R8 grant length", gc, TO);
    chk(ack == 0 && cpu_int == 0, "R8 level released", ack, 0);
    // R2 code 3
    io_write(8'hFF, 8'h03);
    req = 3'b111;
    expect_none("R2 code3 blocks all");
    // R3 no sync without enable
    cpu_ie = 0;
    tick(6);
    chk(sync == 0, "R3 no sync when disabled", sync, 0);
    req = 0;
    tick(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule